// File: doc/BRIEF.md
# Page Write Cache Sequencer

This block sits behind the byte-level slave of a two-wire serial memory. It collects write data into a cache of eight lines, each holding one 8-byte page. When the write is closed it runs a self-timed programming cycle that copies every loaded byte into a synchronous storage array. A write transaction opens with a start strobe that carries the first target address. Data bytes then arrive on a valid/ready stream. A stop strobe closes the transaction and, if at least one byte was loaded, starts programming.

The programming cycle gives each used cache line a window of `PAGE_TICKS` clock cycles. The loaded bytes of that line are written to the array during the first eight cycles of its window. The busy flag stays high for the whole cycle, so the busy time is the per-page time multiplied by the number of lines used. The slave uses busy to withhold acknowledges. Stream back-pressure is simple: `in_ready` is high only while a write is open and no programming is running. A byte moves only on a cycle where `in_valid` and `in_ready` are both high. A byte offered while `in_ready` is low is dropped and is never held for later.

Top module: `page_cache_seq`

## Requirements
- R1: After reset, `busy`, `in_ready` and `arr_we` are all low.
- R2: `in_ready` is high only between an accepted `wr_start` and the following `wr_stop`, and only while `busy` is low. A byte is taken only when `in_valid` and `in_ready` are high in the same cycle. Bytes offered at any other time leave no trace in the array.
- R3: An accepted `wr_start` latches `wr_addr`. Bits [11:3] give the page and bits [2:0] give the offset, and the first data byte is later written at exactly that address.
- R4: Each taken byte advances the offset by one. After offset 7, the next byte goes to offset 0 of the following page, with the page number wrapping from 511 to 0, and it occupies a fresh cache line.
- R5: Once the eighth line has received a byte at offset 7, further bytes wrap to offset 0 of that same last page and overwrite the bytes held there.
- R6: A `wr_stop` while a write is open with at least one byte loaded raises `busy` on the next cycle. A `wr_stop` with no byte loaded closes the write and leaves `busy` low and the array untouched.
- R7: `busy` stays high for exactly N × `PAGE_TICKS` cycles, where N is the number of cache lines that received data.
- R8: In the window of line k (k = 0 for the first line used), `arr_we` pulses in cycle k × `PAGE_TICKS` + j after `busy` rises, for each offset j loaded in that line. In that cycle `arr_addr` is {page, j} and `arr_wdata` is the last byte loaded there. No other array writes happen.
- R9: While `busy` is high, `wr_start`, `wr_stop` and `in_valid` have no effect.
- R10: When programming ends, all cache lines become empty, so the next transaction writes only its own bytes.
- R11: A `wr_start` that arrives while a write is already open discards the bytes loaded so far and restarts at the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_start | input | 1 | Start-of-write strobe, one cycle |
| wr_addr | input | 12 | Start address sampled with `wr_start` |
| in_valid | input | 1 | Data byte offered |
| in_ready | output | 1 | Block can take a data byte |
| in_data | input | 8 | Data byte |
| wr_stop | input | 1 | Stop strobe, one cycle |
| busy | output | 1 | Programming cycle running; slave must not acknowledge |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | 12 | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
The bench goes after page crossings and the wrap from the top page to page 0. A design that kept the same cache line or the same page number at a crossing would write bytes to the wrong addresses. It loads more than 64 bytes to confirm that the last page absorbs the overflow by overwriting. A design that grabbed a ninth line or dropped bytes would show the wrong data or too long a busy time. It times every array write and the busy length against the number of lines used, which catches a timer that is off by one or a length that does not scale. It also probes a stop with no data, a restart in mid-write, and strobes arriving during programming. Each of these would produce a stray programming cycle, leftover bytes from an old transaction, or a write that was accepted while busy.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int DATA_W = 8;
  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/pcs_fill.sv
module pcs_fill #(
  parameter int ADDR_W = 12,
  parameter int OFF_W  = 3,
  parameter int LINES  = 8,
  localparam int LINE_W = $clog2(LINES),
  localparam int PG_W   = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              byte_fire_i,
  input  logic              stop_i,
  input  logic              busy_i,
  output logic              open_o,
  output logic              wr_en_o,
  output logic [LINE_W-1:0] wr_line_o,
  output logic [OFF_W-1:0]  wr_off_o,
  output logic [PG_W-1:0]   wr_page_o,
  output logic              commit_o,
  output logic [LINE_W-1:0] last_line_o,
  output logic              clr_o
);
  localparam logic [OFF_W-1:0]  OFF_MAX = '1;
  localparam logic [LINE_W-1:0] LAST    = LINE_W'(LINES - 1);

  logic              open_q, loaded_q;
  logic [PG_W-1:0]   cur_page;
  logic [OFF_W-1:0]  cur_off;
  logic [LINE_W-1:0] cur_line, used_line;
  logic              start_ok, stop_ok;

  assign start_ok    = start_i && !busy_i;
  assign stop_ok     = stop_i && open_q && !busy_i;
  assign open_o      = open_q;
  assign wr_en_o     = byte_fire_i && open_q && !start_ok && !stop_ok;
  assign wr_line_o   = cur_line;
  assign wr_off_o    = cur_off;
  assign wr_page_o   = cur_page;
  assign commit_o    = stop_ok && loaded_q;
  assign last_line_o = used_line;
  assign clr_o       = start_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      loaded_q  <= 1'b0;
      cur_page  <= '0;
      cur_off   <= '0;
      cur_line  <= '0;
      used_line <= '0;
    end else if (start_ok) begin
      open_q    <= 1'b1;
      loaded_q  <= 1'b0;
      cur_page  <= start_addr_i[ADDR_W-1:OFF_W];
      cur_off   <= start_addr_i[OFF_W-1:0];
      cur_line  <= '0;
      used_line <= '0;
    end else if (stop_ok) begin
      open_q <= 1'b0;
    end else if (wr_en_o) begin
      loaded_q  <= 1'b1;
      used_line <= cur_line;
      if (cur_off == OFF_MAX) begin
        cur_off <= '0;
        if (cur_line != LAST) begin
          cur_line <= cur_line + 1'b1;
          cur_page <= cur_page + 1'b1;
        end
      end else begin
        cur_off <= cur_off + 1'b1;
      end
    end
  end

  // R4
  page_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && cur_off == OFF_MAX && cur_line != LAST)
      |=> (cur_line == $past(cur_line) + 1'b1 && cur_off == '0));

  // R5
  last_page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && cur_off == OFF_MAX && cur_line == LAST)
      |=> (cur_line == LAST && cur_off == '0 && cur_page == $past(cur_page)));
endmodule

// File: rtl/pcs_cache.sv
module pcs_cache
  import pcs_pkg::*;
#(
  parameter int PG_W  = 9,
  parameter int OFF_W = 3,
  parameter int LINES = 8,
  localparam int LINE_W = $clog2(LINES),
  localparam int BYTES  = 1 << OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [LINE_W-1:0] wr_line_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [PG_W-1:0]   wr_page_i,
  input  byte_t             wr_data_i,
  input  logic [LINE_W-1:0] rd_line_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  output byte_t             rd_data_o,
  output logic              rd_loaded_o,
  output logic [PG_W-1:0]   rd_page_o
);
  logic [LINES-1:0][BYTES-1:0][DATA_W-1:0] dat_all;
  logic [LINES-1:0][BYTES-1:0]             msk_all;
  logic [LINES-1:0][PG_W-1:0]              tag_all;

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [BYTES-1:0][DATA_W-1:0] ln_dat;
    logic [BYTES-1:0]             ln_msk;
    logic [PG_W-1:0]              ln_tag;
    logic                         hit;

    assign hit = wr_en_i && (wr_line_i == LINE_W'(l));

    always_ff @(posedge clk) begin
      if (!rst_n || clr_i) ln_msk <= '0;
      else if (hit)        ln_msk[wr_off_i] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hit) begin
        ln_dat[wr_off_i] <= wr_data_i;
        ln_tag           <= wr_page_i;
      end
    end

    assign dat_all[l] = ln_dat;
    assign msk_all[l] = ln_msk;
    assign tag_all[l] = ln_tag;
  end

  assign rd_data_o   = dat_all[rd_line_i][rd_off_i];
  assign rd_loaded_o = msk_all[rd_line_i][rd_off_i];
  assign rd_page_o   = tag_all[rd_line_i];
endmodule

// File: rtl/pcs_prog.sv
module pcs_prog #(
  parameter int OFF_W      = 3,
  parameter int LINES      = 8,
  parameter int PAGE_TICKS = 10000,
  localparam int LINE_W = $clog2(LINES),
  localparam int BYTES  = 1 << OFF_W,
  localparam int TICKS  = (PAGE_TICKS < BYTES) ? BYTES : PAGE_TICKS,
  localparam int TK_W   = $clog2(TICKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic [LINE_W-1:0] last_line_i,
  output logic              busy_o,
  output logic [LINE_W-1:0] rd_line_o,
  output logic [OFF_W-1:0]  rd_off_o,
  output logic              slot_we_o,
  output logic              done_o
);
  localparam logic [TK_W-1:0] TK_END = TK_W'(TICKS - 1);

  logic              busy_q;
  logic [TK_W-1:0]   tick;
  logic [LINE_W-1:0] line, last_line;

  assign busy_o    = busy_q;
  assign rd_line_o = line;
  assign rd_off_o  = tick[OFF_W-1:0];
  assign slot_we_o = busy_q && ({1'b0, tick} < (TK_W + 1)'(BYTES));
  assign done_o    = busy_q && tick == TK_END && line == last_line;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      tick      <= '0;
      line      <= '0;
      last_line <= '0;
    end else if (!busy_q) begin
      if (commit_i) begin
        busy_q    <= 1'b1;
        tick      <= '0;
        line      <= '0;
        last_line <= last_line_i;
      end
    end else if (tick == TK_END) begin
      tick <= '0;
      if (line == last_line) busy_q <= 1'b0;
      else                   line   <= line + 1'b1;
    end else begin
      tick <= tick + 1'b1;
    end
  end

  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(tick) == TK_END && $past(line) == $past(last_line)));
endmodule

// File: rtl/page_cache_seq.sv
module page_cache_seq
  import pcs_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int PAGE_BYTES  = 8,
  parameter int CACHE_LINES = 8,
  parameter int PAGE_TICKS  = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              wr_stop,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_wdata
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PG_W   = ADDR_W - OFF_W;
  localparam int LINE_W = $clog2(CACHE_LINES);

  logic              open_w, fire, wr_en, commit, clr_start, done, slot_we, loaded;
  logic [LINE_W-1:0] wr_line, last_line, rd_line;
  logic [OFF_W-1:0]  wr_off, rd_off;
  logic [PG_W-1:0]   wr_page, rd_page;
  byte_t             rd_data;

  assign in_ready = open_w && !busy;
  assign fire     = in_valid && in_ready;

  pcs_fill #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LINES(CACHE_LINES)) u_fill (
    .clk(clk), .rst_n(rst_n), .start_i(wr_start), .start_addr_i(wr_addr),
    .byte_fire_i(fire), .stop_i(wr_stop), .busy_i(busy), .open_o(open_w),
    .wr_en_o(wr_en), .wr_line_o(wr_line), .wr_off_o(wr_off), .wr_page_o(wr_page),
    .commit_o(commit), .last_line_o(last_line), .clr_o(clr_start)
  );

  pcs_cache #(.PG_W(PG_W), .OFF_W(OFF_W), .LINES(CACHE_LINES)) u_cache (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_start || done), .wr_en_i(wr_en),
    .wr_line_i(wr_line), .wr_off_i(wr_off), .wr_page_i(wr_page), .wr_data_i(in_data),
    .rd_line_i(rd_line), .rd_off_i(rd_off), .rd_data_o(rd_data),
    .rd_loaded_o(loaded), .rd_page_o(rd_page)
  );

  pcs_prog #(.OFF_W(OFF_W), .LINES(CACHE_LINES), .PAGE_TICKS(PAGE_TICKS)) u_prog (
    .clk(clk), .rst_n(rst_n), .commit_i(commit), .last_line_i(last_line),
    .busy_o(busy), .rd_line_o(rd_line), .rd_off_o(rd_off),
    .slot_we_o(slot_we), .done_o(done)
  );

  assign arr_we    = slot_we && loaded;
  assign arr_addr  = {rd_page, rd_off};
  assign arr_wdata = rd_data;

  // R8
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  // R6
  busy_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_stop));
endmodule

// File: tb/page_cache_seq_tb.sv
module page_cache_seq_tb;
  localparam int CLK_NS = 10;
  localparam int T      = 16;
  localparam int AW     = 12;

  logic clk = 0, rst_n = 0, wr_start = 0, in_valid = 0, wr_stop = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    in_data = '0;
  logic          in_ready, busy, arr_we;
  logic [AW-1:0] arr_addr;
  logic [7:0]    arr_wdata;

  page_cache_seq #(.ADDR_W(AW), .PAGE_BYTES(8), .CACHE_LINES(8), .PAGE_TICKS(T)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .wr_stop(wr_stop),
    .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
  );

  always #(CLK_NS/2) clk = ~clk;

  int total = 0, bad = 0;
  int log_a[128], log_d[128], log_c[128];
  int nlog = 0, bcyc = 0, last_len = 0;

  always @(negedge clk) begin
    if (arr_we && nlog < 128) begin
      log_a[nlog] = int'(arr_addr);
      log_d[nlog] = int'(arr_wdata);
      log_c[nlog] = busy ? bcyc : -1;
      nlog++;
    end
    if (busy) begin bcyc++; last_len = bcyc; end
    else bcyc = 0;
  end

  // address(12) | byte count(8) | data seed(8) | lines used(4)
  localparam logic [31:0] VEC [6] = '{
    {12'h000, 8'd1,  8'h3C, 4'd1},  // R3 single byte
    {12'h005, 8'd3,  8'h50, 4'd1},  // R4 runs to end of page
    {12'h006, 8'd4,  8'h70, 4'd2},  // R4 crosses into next page
    {12'h100, 8'd64, 8'h00, 4'd8},  // full cache
    {12'h013, 8'd70, 8'h90, 4'd8},  // R5 overflow into last page
    {12'hFFE, 8'd4,  8'hE0, 4'd2}   // R4 wrap from top page to page 0
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic open_wr(input int a);
    @(negedge clk); wr_start = 1; wr_addr = AW'(a);
    @(negedge clk); wr_start = 0;
  endtask

  task automatic put(input int d);
    chk(in_ready == 1'b1, "R2 ready while open", int'(in_ready), 1);
    in_valid = 1; in_data = 8'(d);
    @(negedge clk); in_valid = 0;
  endtask

  task automatic close_wr();
    wr_stop = 1; @(negedge clk); wr_stop = 0;
  endtask

  task automatic wait_idle();
    for (int g = 0; busy && g < 2000; g++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_vec(input int a, input int n, input int seed, input int lines);
    int epg[8]; bit [7:0] emsk[8]; int edat[8][8];
    int line, pg, off, used, idx;
    for (int k = 0; k < 8; k++) emsk[k] = '0;
    line = 0; pg = a / 8; off = a % 8; used = 0;
    for (int i = 0; i < n; i++) begin
      epg[line] = pg; emsk[line][off] = 1'b1; edat[line][off] = (seed + i) % 256;
      used = line + 1;
      if (off == 7) begin
        off = 0;
        if (line < 7) begin line++; pg = (pg + 1) % 512; end
      end else off++;
    end
    nlog = 0;
    open_wr(a);
    for (int i = 0; i < n; i++) put(seed + i);
    close_wr();
    chk(busy == 1'b1, "R6 busy after stop", int'(busy), 1);
    wait_idle();
    chk(used == lines, "R4 lines used by model", used, lines);
    chk(last_len == used * T, "R7 busy length", last_len, used * T);
    idx = 0;
    for (int k = 0; k < used; k++)
      for (int j = 0; j < 8; j++)
        if (emsk[k][j]) begin
          if (idx < nlog) begin
            chk(log_a[idx] == epg[k] * 8 + j, "R8 write address", log_a[idx], epg[k] * 8 + j);
            chk(log_d[idx] == edat[k][j], "R5 write data", log_d[idx], edat[k][j]);
            chk(log_c[idx] == k * T + j, "R8 write cycle", log_c[idx], k * T + j);
          end
          idx++;
        end
    chk(nlog == idx, "R10 write count", nlog, idx);
  endtask

  initial begin
    #(CLK_NS * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(in_ready == 1'b0, "R1 in_ready", int'(in_ready), 0);
    chk(arr_we == 1'b0, "R1 arr_we", int'(arr_we), 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < 6; v++)
      run_vec(int'(VEC[v][31:20]), int'(VEC[v][19:12]), int'(VEC[v][11:4]), int'(VEC[v][3:0]));

    // R2 byte offered with no write open, R6 stop with no data
    nlog = 0;
    in_valid = 1; in_data = 8'h77; @(negedge clk); in_valid = 0;
    open_wr(12'h020);
    close_wr();
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R6 empty stop no busy", int'(busy), 0);
    chk(nlog == 0, "R2 dropped byte not written", nlog, 0);
    chk(in_ready == 1'b0, "R2 ready low after stop", int'(in_ready), 0);

    // R11 restart discards loaded bytes
    nlog = 0;
    open_wr(12'h040); put(8'hAA); put(8'hBB);
    open_wr(12'h080); put(8'h5C);
    close_wr(); wait_idle();
    chk(nlog == 1, "R11 write count", nlog, 1);
    chk(log_a[0] == 12'h080, "R11 address", log_a[0], 12'h080);
    chk(log_d[0] == 8'h5C, "R11 data", log_d[0], 8'h5C);
    chk(last_len == T, "R11 busy length", last_len, T);

    // R9 strobes during programming have no effect
    nlog = 0;
    open_wr(12'h200); put(8'h11);
    close_wr();
    chk(in_ready == 1'b0, "R9 ready low while busy", int'(in_ready), 0);
    wr_start = 1; wr_addr = 12'h300; @(negedge clk); wr_start = 0;
    in_valid = 1; in_data = 8'h99; @(negedge clk); in_valid = 0;
    wr_stop = 1; @(negedge clk); wr_stop = 0;
    wait_idle();
    chk(last_len == T, "R9 busy length", last_len, T);
    chk(nlog == 1, "R9 write count", nlog, 1);
    chk(log_a[0] == 12'h200, "R9 address", log_a[0], 12'h200);
    chk(in_ready == 1'b0, "R9 start ignored", int'(in_ready), 0);
    wr_stop = 1; @(negedge clk); wr_stop = 0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R9 no stray cycle", int'(busy), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule